// File: doc/BRIEF.md
# Valid/Ready Stream Link Monitor

This block is a passive observer placed on a single point-to-point stream link. The link has a data bus, a valid strobe driven by the sender and a ready acknowledge driven by the receiver, all on one clock with a synchronous active-high reset. The monitor never drives the link. It samples the link on every rising edge and reports three things. The first is a count of completed transfers. The second is the data word of the most recent transfer. The third is a vector of sticky violation flags, one bit per handshake rule.

A transfer completes on each rising edge that samples valid and ready both high. Both handshake signals may stay high across consecutive edges, and each such edge moves one word. Once raised, valid must stay high until its transfer completes. Ready follows the same rule. The data bus must not change while an offered word waits. The receiver may hold ready low until valid appears. The sender must not hold valid low while waiting for ready, so a long run of ready high with valid low raises a liveness flag.

Top module: `hs_link_monitor`

## Requirements
- R1: Any edge that samples reset high clears the transfer count, the last word and every flag. The next edge starts with no transfer history, so a word left pending when reset came raises no flag.
- R2: Each rising edge that samples valid=1 and ready=1 with reset low adds one to the transfer count. Back-to-back edges with both high each count.
- R3: On each completing edge, the last-word output takes the data bus value sampled at that edge. At all other times it holds its value.
- R4: Flag bit 1 (sender withdrawal) is set when valid is sampled 0 one edge after valid=1 and ready=0 were sampled.
- R5: Flag bit 2 (receiver withdrawal) is set when ready is sampled 0 one edge after ready=1 and valid=0 were sampled.
- R6: Flag bit 3 (data instability) is set when valid=1 at two successive edges, the first of them did not complete, and the data differs between them. Data is never compared while valid is 0. Data is also not compared across an edge that completed a transfer.
- R7: Flag bit 0 (reset leak) is set when, at the first edge with reset low after an edge with reset high, valid or ready is sampled 1.
- R8: Flag bit 4 (sender stall) is set at the WAIT_LIMIT-th consecutive edge with ready=1 and valid=0. Any other edge restarts that run.
- R9: Flag bits, once set, stay set until reset.
- R10: The transfer count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| lnk_data | input | DATA_W | Observed data bus |
| lnk_valid | input | 1 | Observed sender strobe |
| lnk_ready | input | 1 | Observed receiver acknowledge |
| xfer_count | output | CNT_W | Saturating count of completed transfers |
| last_word | output | DATA_W | Data of the most recent completed transfer |
| err_flags | output | 5 | Sticky violation flags (bit 0 reset leak, 1 sender withdrawal, 2 receiver withdrawal, 3 data instability, 4 sender stall) |

## Verification
The two functions that can act on the same edge are transfer completion and the data-stability rule. On the cycle after a completion, the sender may legally present a new word while valid stays high. The stimulus streams several words with both handshakes high and a fresh data value on every edge. It then checks that the count and last word advance on each edge and that flag bit 3 stays clear. A later vector changes data while a word is still unanswered, and that vector must raise flag bit 3.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
   localparam int ERR_RST_LEAK   = 0;
   localparam int ERR_VALID_DROP = 1;
   localparam int ERR_READY_DROP = 2;
   localparam int ERR_DATA_MOVE  = 3;
   localparam int ERR_TX_STALL   = 4;
   localparam int NUM_RULES      = 5;

   typedef logic [NUM_RULES-1:0] rule_vec_t;
endpackage

// File: rtl/hs_mon_sampler.sv
module hs_mon_sampler #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   input  logic              ready_i,
   output logic [DATA_W-1:0] data_q,
   output logic              valid_q,
   output logic              ready_q,
   output logic              rst_q
);
   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         data_q  <= data_i;
         valid_q <= valid_i;
         ready_q <= ready_i;
      end
   end
endmodule

// File: rtl/hs_mon_stall_timer.sv
module hs_mon_stall_timer #(
   parameter int WAIT_LIMIT = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic valid_i,
   input  logic ready_i,
   output logic stall_hit
);
   localparam int TW = $clog2(WAIT_LIMIT + 1);
   localparam logic [TW-1:0] LIMIT_M1 = TW'(WAIT_LIMIT - 1);
   localparam logic [TW-1:0] LIMIT    = TW'(WAIT_LIMIT);

   logic [TW-1:0] run_cnt;
   logic          waiting;

   assign waiting   = ready_i && !valid_i;
   assign stall_hit = waiting && (run_cnt == LIMIT_M1);

   always_ff @(posedge clk) begin
      if (rst || !waiting) begin
         run_cnt <= '0;
      end else if (run_cnt != LIMIT) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hs_mon_rules.sv
module hs_mon_rules
   import hs_mon_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   input  logic              ready_i,
   input  logic [DATA_W-1:0] data_q,
   input  logic              valid_q,
   input  logic              ready_q,
   input  logic              rst_q,
   input  logic              stall_hit,
   output rule_vec_t         flags
);
   rule_vec_t viol;
   logic      pend_valid;
   logic      pend_ready;

   assign pend_valid = valid_q && !ready_q;
   assign pend_ready = ready_q && !valid_q;

   always_comb begin
      viol                 = '0;
      viol[ERR_RST_LEAK]   = rst_q && (valid_i || ready_i);
      viol[ERR_VALID_DROP] = pend_valid && !valid_i;
      viol[ERR_READY_DROP] = pend_ready && !ready_i;
      viol[ERR_DATA_MOVE]  = pend_valid && valid_i && (data_i != data_q);
      viol[ERR_TX_STALL]   = stall_hit;
   end

   for (genvar b = 0; b < NUM_RULES; b++) begin : g_sticky
      always_ff @(posedge clk) begin
         if (rst) flags[b] <= 1'b0;
         else if (viol[b]) flags[b] <= 1'b1;
      end
   end
endmodule

// File: rtl/hs_mon_xfer_track.sv
module hs_mon_xfer_track #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   input  logic              ready_i,
   output logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] last
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   logic fire;
   assign fire = valid_i && ready_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
         last  <= '0;
      end else if (fire) begin
         last <= data_i;
         if (count != CNT_MAX) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
   import hs_mon_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 32,
   parameter int WAIT_LIMIT = 256
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [DATA_W-1:0]    lnk_data,
   input  logic                 lnk_valid,
   input  logic                 lnk_ready,
   output logic [CNT_W-1:0]     xfer_count,
   output logic [DATA_W-1:0]    last_word,
   output logic [NUM_RULES-1:0] err_flags
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (WAIT_LIMIT < 2) begin : g_bad_limit
      $error("WAIT_LIMIT must be at least 2");
   end

   logic [DATA_W-1:0] data_q;
   logic              valid_q;
   logic              ready_q;
   logic              rst_q;
   logic              stall_hit;
   rule_vec_t         flags;

   hs_mon_sampler #(.DATA_W(DATA_W)) u_sampler (
      .clk(clk), .rst(rst), .data_i(lnk_data), .valid_i(lnk_valid),
      .ready_i(lnk_ready), .data_q(data_q), .valid_q(valid_q),
      .ready_q(ready_q), .rst_q(rst_q)
   );

   hs_mon_stall_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_stall (
      .clk(clk), .rst(rst), .valid_i(lnk_valid), .ready_i(lnk_ready),
      .stall_hit(stall_hit)
   );

   hs_mon_rules #(.DATA_W(DATA_W)) u_rules (
      .clk(clk), .rst(rst), .data_i(lnk_data), .valid_i(lnk_valid),
      .ready_i(lnk_ready), .data_q(data_q), .valid_q(valid_q),
      .ready_q(ready_q), .rst_q(rst_q), .stall_hit(stall_hit),
      .flags(flags)
   );

   hs_mon_xfer_track #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst(rst), .data_i(lnk_data), .valid_i(lnk_valid),
      .ready_i(lnk_ready), .count(xfer_count), .last(last_word)
   );

   assign err_flags = flags;
endmodule

// File: rtl/hs_link_monitor_chk.sv
module hs_link_monitor_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] lnk_data,
   input logic              lnk_valid,
   input logic              lnk_ready,
   input logic [CNT_W-1:0]  xfer_count,
   input logic [DATA_W-1:0] last_word,
   input logic [4:0]        err_flags
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (lnk_valid && lnk_ready && xfer_count != CMAX) |=> (xfer_count == $past(xfer_count) + 1'b1)); // R2
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(lnk_valid && lnk_ready) |=> $stable(xfer_count)); // R2
   AST_LAST_WORD: assert property (@(posedge clk) disable iff (rst)
      (lnk_valid && lnk_ready) |=> (last_word == $past(lnk_data))); // R3
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
      (lnk_valid && !lnk_ready) ##1 !lnk_valid |=> err_flags[1]); // R4
   AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
      (lnk_ready && !lnk_valid) ##1 !lnk_ready |=> err_flags[2]); // R5
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
      (err_flags != 5'd0) |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R9
   AST_COUNT_SAT: assert property (@(posedge clk) disable iff (rst)
      (xfer_count == CMAX) |=> (xfer_count == CMAX)); // R10
endmodule

bind hs_link_monitor hs_link_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .lnk_data(lnk_data), .lnk_valid(lnk_valid),
   .lnk_ready(lnk_ready), .xfer_count(xfer_count), .last_word(last_word),
   .err_flags(err_flags)
);

// File: tb/hs_link_monitor_tb_top.sv
`timescale 1ns/100ps
module hs_link_monitor_tb_top;
   localparam int DW = 8;
   localparam int CW = 4;
   localparam int WL = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] data = '0;
   logic          valid = 1'b0;
   logic          ready = 1'b0;
   logic [CW-1:0] cnt;
   logic [DW-1:0] last;
   logic [4:0]    err;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   hs_link_monitor #(.DATA_W(DW), .CNT_W(CW), .WAIT_LIMIT(WL)) dut_i (
      .clk(clk), .rst(rst), .lnk_data(data), .lnk_valid(valid),
      .lnk_ready(ready), .xfer_count(cnt), .last_word(last), .err_flags(err)
   );

   // {valid, ready, data, exp count, exp last, exp flags}
   typedef struct packed {
      logic          v;
      logic          r;
      logic [DW-1:0] d;
      logic [CW-1:0] c;
      logic [DW-1:0] l;
      logic [4:0]    e;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VT [NV] = '{
      '{1'b0, 1'b0, 8'hAA, 4'd0, 8'h00, 5'h00},
      '{1'b1, 1'b0, 8'h11, 4'd0, 8'h00, 5'h00},
      '{1'b1, 1'b0, 8'h11, 4'd0, 8'h00, 5'h00},
      '{1'b1, 1'b1, 8'h11, 4'd1, 8'h11, 5'h00},
      '{1'b1, 1'b1, 8'h22, 4'd2, 8'h22, 5'h00},
      '{1'b1, 1'b1, 8'h33, 4'd3, 8'h33, 5'h00},
      '{1'b0, 1'b1, 8'h55, 4'd3, 8'h33, 5'h00},
      '{1'b0, 1'b1, 8'h66, 4'd3, 8'h33, 5'h00},
      '{1'b1, 1'b1, 8'h44, 4'd4, 8'h44, 5'h00},
      '{1'b0, 1'b0, 8'h00, 4'd4, 8'h44, 5'h00},
      '{1'b1, 1'b0, 8'h77, 4'd4, 8'h44, 5'h00},
      '{1'b1, 1'b0, 8'h78, 4'd4, 8'h44, 5'h08},
      '{1'b1, 1'b1, 8'h78, 4'd5, 8'h78, 5'h08},
      '{1'b1, 1'b0, 8'h90, 4'd5, 8'h78, 5'h08},
      '{1'b0, 1'b0, 8'h90, 4'd5, 8'h78, 5'h0A},
      '{1'b0, 1'b1, 8'h00, 4'd5, 8'h78, 5'h0A},
      '{1'b0, 1'b0, 8'h00, 4'd5, 8'h78, 5'h0E}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic r, input logic [DW-1:0] d);
      @(negedge clk);
      valid = v; ready = r; data = d;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; valid = 1'b0; ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset count", int'(cnt), 0);
      chk("R1 reset last", int'(last), 0);
      chk("R1 reset flags", int'(err), 0);
      @(negedge clk);
      rst = 1'b0;

      // R2 R3 R4 R5 R6 R9: vector walk; back-to-back words with new data must not set bit 3
      for (int i = 0; i < NV; i++) begin
         step(VT[i].v, VT[i].r, VT[i].d);
         chk($sformatf("R2 count v%0d", i), int'(cnt), int'(VT[i].c));
         chk($sformatf("R3 last v%0d", i), int'(last), int'(VT[i].l));
         chk($sformatf("R6/R4/R5/R9 flags v%0d", i), int'(err), int'(VT[i].e));
      end

      // R1: reset clears state and a word pending at reset raises nothing afterwards
      do_reset();
      step(1'b1, 1'b0, 8'h5A);
      do_reset();
      step(1'b0, 1'b0, 8'h00);
      chk("R1 after reset count", int'(cnt), 0);
      chk("R1 after reset flags", int'(err), 0);

      // R10: saturation at 15 with CNT_W=4
      for (int k = 0; k < 18; k++) step(1'b1, 1'b1, 8'(k));
      chk("R10 saturated count", int'(cnt), 15);
      chk("R3 last after stream", int'(last), 17);
      chk("R6 stream flags clear", int'(err), 0);

      // R8: run of WL-1 waiting edges, broken, then WL edges
      do_reset();
      for (int k = 0; k < WL - 1; k++) step(1'b0, 1'b1, 8'h00);
      chk("R8 below limit", int'(err[4]), 0);
      step(1'b1, 1'b1, 8'h01);
      for (int k = 0; k < WL - 1; k++) step(1'b0, 1'b1, 8'h00);
      chk("R8 run restarted", int'(err[4]), 0);
      step(1'b0, 1'b1, 8'h00);
      chk("R8 limit reached", int'(err[4]), 1);
      step(1'b1, 1'b1, 8'h02);
      step(1'b0, 1'b0, 8'h00);
      chk("R9 stall flag held", int'(err[4]), 1);

      // R7: valid high at first edge after reset
      @(negedge clk);
      rst = 1'b1; valid = 1'b0; ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; valid = 1'b1; ready = 1'b0; data = 8'h3C;
      @(posedge clk);
      #1;
      chk("R7 reset leak valid", int'(err), 5'h01);
      // R7: ready high variant
      @(negedge clk);
      rst = 1'b1; valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; ready = 1'b1;
      @(posedge clk);
      #1;
      chk("R7 reset leak ready", int'(err[0]), 1);
      // R6: data change not checked while valid low
      do_reset();
      step(1'b0, 1'b0, 8'h10);
      step(1'b0, 1'b0, 8'h20);
      step(1'b0, 1'b0, 8'h30);
      chk("R6 idle data ignored", int'(err), 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule